// File: doc/BRIEF.md
# Speculation Status Table

This block keeps the speculative status of the threads in flight in a pipeline. A thread that starts a speculative child asks the spawn port for an identifier. The table hands out identifiers from a circular buffer in order. Later, the parent resolves that identifier as correct or mispredicted. A misprediction also condemns every entry that was handed out after the resolved one, because those threads descend from a wrong guess.

Threads learn their fate through two check ports:
- The non-blocking check reports a kill for a mispredicted entry and otherwise lets the thread go on.
- The blocking check holds the thread with a stall while its entry is still unresolved, then reports kill or proceed.

A resolve and a check presented in the same cycle see each other through a combinational path. This lets a pipeline speculate and resolve every cycle.

An entry becomes free once its thread has seen a resolved status. Space is reclaimed strictly from the oldest end, one entry per cycle. An entry freed early therefore waits until the oldest pointer reaches it.

Each entry holds a 2-bit state: 0 free, 1 pending, 2 correct, 3 mispredicted.

Top module: `spec_status_table`

## Requirements
- R1: When `spawn_req` is high and `spawn_ok` is high, the entry whose index is shown on `spawn_id` becomes pending at the clock edge. Identifiers are issued in increasing order and wrap from DEPTH-1 to 0.
- R2: When DEPTH entries are occupied, `spawn_ok` is low. A spawn request in that state allocates nothing, and `spawn_id` keeps its value.
- R3: A resolve (`res_valid`, with `res_mispred` 1 for mispredicted and 0 for correct) sets a pending entry to correct or mispredicted. A later resolve of an entry that is already mispredicted leaves it mispredicted.
- R4: A mispredicted resolve also marks mispredicted every occupied entry allocated after the resolved one. Older entries keep their state.
- R5: The non-blocking check raises `nb_kill` only for a mispredicted entry. It frees the entry only if the entry is resolved; a pending entry stays pending.
- R6: The blocking check behaves as follows. For a pending entry, `bar_stall` is high and `bar_kill` is low. For a mispredicted entry, `bar_kill` is high and `bar_stall` is low. For a correct entry, both are low. A resolved entry that is checked is freed.
- R7: A resolve and a check in the same cycle bypass: the check reports the state after the resolve and after its cascade.
- R8: Storage is reclaimed at the oldest entry, at most one per cycle, and only once that entry is free. Entries freed out of order count as occupied until the oldest pointer passes them.
- R9: After reset the table is empty: `spawn_ok` is 1, `spawn_id` is 0 and every entry is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spawn_req | input | 1 | Request a new speculation identifier |
| spawn_ok | output | 1 | Table has room; a request is granted |
| spawn_id | output | IDW | Identifier given to a granted request |
| res_valid | input | 1 | Resolve an entry this cycle |
| res_id | input | IDW | Entry being resolved |
| res_mispred | input | 1 | 1 mispredicted, 0 correct |
| nb_valid | input | 1 | Non-blocking status check |
| nb_id | input | IDW | Entry checked without blocking |
| nb_kill | output | 1 | Checked thread must be killed |
| bar_valid | input | 1 | Blocking status check |
| bar_id | input | IDW | Entry checked with blocking |
| bar_stall | output | 1 | Entry unresolved; hold the thread |
| bar_kill | output | 1 | Entry mispredicted; kill the thread |

## Verification
The bench goes after several corner cases, each with a visible failure:
- Same-cycle bypass. A design without it would stall or let through a thread resolved in that very cycle.
- Cascade on a wrapped buffer, with an older pending entry alongside. A wrong age comparison would either kill the older thread or spare a younger one.
- A correct verdict arriving after a cascade. It must not revive an entry that the cascade already condemned.
- A full table with entries freed out of order. A design that reclaimed them early would grant a spawn while the oldest entry is still pending.
- Reset in the middle of activity. It must empty the table.

// File: rtl/sst_pkg.sv
// Shared types and helpers for the speculation status table.
package sst_pkg;
    // Per-entry state; encoding is visible in the brief.
    typedef enum logic [1:0] {
        SST_FREE = 2'd0,
        SST_PEND = 2'd1,
        SST_GOOD = 2'd2,
        SST_BAD  = 2'd3
    } sst_state_e;

    // Distance of slot idx from the oldest slot tl in a ring of depth slots.
    function automatic int sst_age(int idx, int tl, int depth);
        return (idx >= tl) ? idx - tl : idx + depth - tl;
    endfunction
endpackage

// File: rtl/sst_ring_ctrl.sv
// Ring pointer control: newest (head), oldest (tail) and occupancy count.
// Assumes alloc is only raised when not full and retire only when count > 0.
module sst_ring_ctrl #(
    parameter int DEPTH = 8,
    localparam int IDW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc,
    input  logic           retire,
    output logic [IDW-1:0] head,
    output logic [IDW-1:0] tail,
    output logic [CW-1:0]  count,
    output logic           full
);
    // Next slot index with wrap at DEPTH.
    function automatic logic [IDW-1:0] step(logic [IDW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (alloc)  head <= step(head);
            if (retire) tail <= step(tail);
            count <= count + CW'(alloc) - CW'(retire);
        end
    end

    // Full flag from occupancy.
    assign full = (count == CW'(DEPTH));
endmodule

// File: rtl/sst_view.sv
// Combinational status view of one entry after this cycle's resolve.
// Assumes hit_younger is only set for occupied entries newer than the target.
module sst_view import sst_pkg::*; (
    input  sst_state_e cur,
    input  logic       res_valid,
    input  logic       res_mis,
    input  logic       hit_target,
    input  logic       hit_younger,
    output sst_state_e view
);
    // Apply the direct verdict or the cascading misprediction.
    always_comb begin
        view = cur;
        if (res_valid && cur != SST_FREE) begin
            if (hit_target) begin
                if (cur != SST_BAD) view = res_mis ? SST_BAD : SST_GOOD;
            end else if (hit_younger && res_mis) begin
                view = SST_BAD;
            end
        end
    end
endmodule

// File: rtl/sst_entry.sv
// State register of one table entry. Allocation wins over release,
// release wins over the resolved view.
module sst_entry import sst_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alloc,
    input  logic       release_req,
    input  sst_state_e view,
    output sst_state_e state
);
    // Update the entry state.
    always_ff @(posedge clk) begin
        if (!rst_n)           state <= SST_FREE;
        else if (alloc)       state <= SST_PEND;
        else if (release_req) state <= SST_FREE;
        else                  state <= view;
    end
endmodule

// File: rtl/spec_status_table.sv
// Speculation status table: circular buffer of speculative-thread states
// with spawn, resolve, non-blocking and blocking check ports. A resolve and
// a check in the same cycle are bypassed. Assumes ids presented on the
// resolve and check ports are below DEPTH.
module spec_status_table import sst_pkg::*; #(
    parameter int DEPTH = 8,
    localparam int IDW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           spawn_req,
    output logic           spawn_ok,
    output logic [IDW-1:0] spawn_id,
    input  logic           res_valid,
    input  logic [IDW-1:0] res_id,
    input  logic           res_mispred,
    input  logic           nb_valid,
    input  logic [IDW-1:0] nb_id,
    output logic           nb_kill,
    input  logic           bar_valid,
    input  logic [IDW-1:0] bar_id,
    output logic           bar_stall,
    output logic           bar_kill
);
    logic [IDW-1:0] head, tail;
    logic [CW-1:0]  count;
    logic           full, retire, grant;
    int             res_age;
    sst_state_e     cur  [DEPTH];
    sst_state_e     view [DEPTH];

    assign grant    = spawn_req && !full;
    assign spawn_ok = !full;
    assign spawn_id = head;

    sst_ring_ctrl #(.DEPTH(DEPTH)) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .alloc  (grant),
        .retire (retire),
        .head   (head),
        .tail   (tail),
        .count  (count),
        .full   (full)
    );

    // Age of the resolved entry relative to the oldest.
    always_comb res_age = sst_age(int'(res_id), int'(tail), DEPTH);

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        int   age_g;
        logic young_g, tgt_g, rel_g, alloc_g;

        // Decode this entry's relation to the resolve and check ports.
        always_comb begin
            age_g   = sst_age(g, int'(tail), DEPTH);
            young_g = (age_g < int'(count)) && (age_g > res_age);
            tgt_g   = (int'(res_id) == g);
            alloc_g = grant && (int'(head) == g);
            rel_g   = ((nb_valid && int'(nb_id) == g) ||
                       (bar_valid && int'(bar_id) == g)) &&
                      (view[g] == SST_GOOD || view[g] == SST_BAD);
        end

        sst_view u_view (
            .cur         (cur[g]),
            .res_valid   (res_valid),
            .res_mis     (res_mispred),
            .hit_target  (tgt_g),
            .hit_younger (young_g),
            .view        (view[g])
        );

        sst_entry u_entry (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc       (alloc_g),
            .release_req (rel_g),
            .view        (view[g]),
            .state       (cur[g])
        );
    end

    // Reclaim the oldest slot once it is free.
    assign retire = (count != '0) && (cur[tail] == SST_FREE);

    // Check port results from the bypassed view.
    always_comb begin
        nb_kill   = 1'b0;
        bar_stall = 1'b0;
        bar_kill  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (nb_valid && int'(nb_id) == i && view[i] == SST_BAD)
                nb_kill = 1'b1;
            if (bar_valid && int'(bar_id) == i) begin
                bar_stall = (view[i] == SST_PEND);
                bar_kill  = (view[i] == SST_BAD);
            end
        end
    end
endmodule

// File: rtl/sst_checker.sv
// Port-level properties of the speculation status table, bound to the top.
module sst_checker #(
    parameter int DEPTH = 8,
    localparam int IDW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           spawn_req,
    input logic           spawn_ok,
    input logic [IDW-1:0] spawn_id,
    input logic           res_valid,
    input logic [IDW-1:0] res_id,
    input logic           bar_valid,
    input logic [IDW-1:0] bar_id,
    input logic           bar_stall,
    input logic           bar_kill
);
    // Granted spawns step the identifier with wrap (R1).
    p_alloc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spawn_req && spawn_ok |=>
        spawn_id == ((int'($past(spawn_id)) == DEPTH - 1) ? '0 : $past(spawn_id) + 1'b1));

    // Refused spawn leaves the identifier alone (R2).
    p_refused_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spawn_req && !spawn_ok |=> $stable(spawn_id));

    // Stall and kill never together on the blocking check (R6).
    p_stall_kill_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bar_stall && bar_kill));

    // A same-cycle resolve of the checked entry never stalls (R7).
    p_bypass_nostall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && bar_valid && bar_id == res_id |-> !bar_stall);

    // First cycle after reset: empty table, identifier zero (R9).
    p_reset_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> spawn_ok && spawn_id == '0);
endmodule

bind spec_status_table sst_checker #(.DEPTH(DEPTH)) u_sst_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .spawn_req (spawn_req),
    .spawn_ok  (spawn_ok),
    .spawn_id  (spawn_id),
    .res_valid (res_valid),
    .res_id    (res_id),
    .bar_valid (bar_valid),
    .bar_id    (bar_id),
    .bar_stall (bar_stall),
    .bar_kill  (bar_kill)
);

// File: tb/spec_status_table_bench.sv
module spec_status_table_bench;
    localparam int DEPTH = 4;
    localparam int IDW   = 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           spawn_req, spawn_ok;
    logic [IDW-1:0] spawn_id;
    logic           res_valid, res_mispred;
    logic [IDW-1:0] res_id;
    logic           nb_valid, nb_kill;
    logic [IDW-1:0] nb_id;
    logic           bar_valid, bar_stall, bar_kill;
    logic [IDW-1:0] bar_id;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;  // 50 MHz

    spec_status_table #(.DEPTH(DEPTH)) u_spec_status_table (
        .clk(clk), .rst_n(rst_n),
        .spawn_req(spawn_req), .spawn_ok(spawn_ok), .spawn_id(spawn_id),
        .res_valid(res_valid), .res_id(res_id), .res_mispred(res_mispred),
        .nb_valid(nb_valid), .nb_id(nb_id), .nb_kill(nb_kill),
        .bar_valid(bar_valid), .bar_id(bar_id),
        .bar_stall(bar_stall), .bar_kill(bar_kill)
    );

    typedef struct packed {
        logic [3:0]     req;
        logic           sp;
        logic           rv;
        logic [IDW-1:0] rid;
        logic           rm;
        logic           nv;
        logic [IDW-1:0] nid;
        logic           bv;
        logic [IDW-1:0] bid;
        logic           eok;
        logic [IDW-1:0] eid;
        logic           enk;
        logic           ebs;
        logic           ebk;
    } vec_t;

    // req, sp, rv, rid, rm, nv, nid, bv, bid | eok, eid, enk, ebs, ebk
    localparam vec_t VEC [25] = '{
        '{4'd9, 1,0,0,0, 0,0, 0,0, 1,0,0,0,0},  // R9 first id is 0
        '{4'd6, 1,0,0,0, 0,0, 1,0, 1,1,0,1,0},  // R6 pending stalls
        '{4'd7, 1,1,0,0, 0,0, 1,0, 1,2,0,0,0},  // R7 same-cycle correct
        '{4'd5, 1,0,0,0, 1,1, 0,0, 1,3,0,0,0},  // R5 pending not killed
        '{4'd4, 0,1,2,1, 1,3, 1,1, 1,0,1,1,0},  // R4 cascade, older kept
        '{4'd3, 0,0,0,0, 1,2, 1,1, 1,0,1,1,0},  // R3 stored mispredict
        '{4'd6, 0,1,1,0, 0,0, 1,1, 1,0,0,0,0},  // R6 correct proceeds
        '{4'd8, 0,0,0,0, 0,0, 0,0, 1,0,0,0,0},  // R8 drain
        '{4'd8, 0,0,0,0, 0,0, 0,0, 1,0,0,0,0},
        '{4'd8, 0,0,0,0, 0,0, 0,0, 1,0,0,0,0},
        '{4'd1, 1,0,0,0, 0,0, 0,0, 1,0,0,0,0},  // R1 fill
        '{4'd1, 1,0,0,0, 0,0, 0,0, 1,1,0,0,0},
        '{4'd1, 1,0,0,0, 0,0, 0,0, 1,2,0,0,0},
        '{4'd1, 1,0,0,0, 0,0, 0,0, 1,3,0,0,0},
        '{4'd2, 1,0,0,0, 0,0, 0,0, 0,0,0,0,0},  // R2 full refuses
        '{4'd4, 0,1,1,1, 1,2, 1,0, 0,0,1,1,0},  // R4 cascade on full ring
        '{4'd6, 0,0,0,0, 1,3, 1,1, 0,0,1,0,1},  // R6 mispredicted kills
        '{4'd5, 0,1,0,0, 1,0, 0,0, 0,0,0,0,0},  // R5 correct no kill
        '{4'd8, 0,0,0,0, 0,0, 0,0, 0,0,0,0,0},  // R8 still full
        '{4'd8, 1,0,0,0, 0,0, 0,0, 1,0,0,0,0},  // R8 one slot back
        '{4'd8, 0,0,0,0, 0,0, 0,0, 1,1,0,0,0},
        '{4'd8, 0,0,0,0, 0,0, 0,0, 1,1,0,0,0},
        '{4'd1, 1,0,0,0, 0,0, 0,0, 1,1,0,0,0},
        '{4'd4, 0,1,0,1, 1,0, 0,0, 1,2,1,0,0},  // R4 cascade to id1
        '{4'd3, 0,1,1,0, 1,1, 0,0, 1,2,1,0,0}   // R3 correct cannot revive
    };

    task automatic check(input string req, input string what,
                         input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
        end
    endtask

    task automatic idle_inputs();
        spawn_req = 0; res_valid = 0; res_id = 0; res_mispred = 0;
        nb_valid = 0; nb_id = 0; bar_valid = 0; bar_id = 0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #5;
        check("R9", "reset spawn_ok", int'(spawn_ok), 1);
        check("R9", "reset spawn_id", int'(spawn_id), 0);

        for (int v = 0; v < 25; v++) begin
            string tag;
            if (v > 0) @(negedge clk);
            tag = $sformatf("R%0d v%0d", VEC[v].req, v);
            spawn_req   = VEC[v].sp;
            res_valid   = VEC[v].rv;
            res_id      = VEC[v].rid;
            res_mispred = VEC[v].rm;
            nb_valid    = VEC[v].nv;
            nb_id       = VEC[v].nid;
            bar_valid   = VEC[v].bv;
            bar_id      = VEC[v].bid;
            #5;
            check(tag, "spawn_ok",  int'(spawn_ok),  int'(VEC[v].eok));
            check(tag, "spawn_id",  int'(spawn_id),  int'(VEC[v].eid));
            check(tag, "nb_kill",   int'(nb_kill),   int'(VEC[v].enk));
            check(tag, "bar_stall", int'(bar_stall), int'(VEC[v].ebs));
            check(tag, "bar_kill",  int'(bar_kill),  int'(VEC[v].ebk));
        end

        // Directed R9: reset in the middle of activity empties the table.
        @(negedge clk);
        idle_inputs();
        spawn_req = 1;
        @(negedge clk);
        spawn_req = 0;
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        bar_valid = 1; bar_id = 0;
        #5;
        check("R9", "mid reset spawn_ok", int'(spawn_ok), 1);
        check("R9", "mid reset spawn_id", int'(spawn_id), 0);
        check("R9", "mid reset entry0 stall", int'(bar_stall), 0);
        check("R9", "mid reset entry0 kill", int'(bar_kill), 0);

        // Directed R1: fresh allocation after reset is pending.
        @(negedge clk);
        bar_valid = 0; spawn_req = 1;
        @(negedge clk);
        spawn_req = 0; bar_valid = 1; bar_id = 0;
        #5;
        check("R1", "new entry stalls", int'(bar_stall), 1);
        check("R1", "next id", int'(spawn_id), 1);

        @(negedge clk);
        idle_inputs();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule